// File: doc/BRIEF.md
# Filtered External Interrupt Edge Detector

This block turns three asynchronous interrupt pins into sticky request flags. Pin A passes through a two-flop synchronizer and then a sampling filter. The filter's level moves only when two consecutive sample ticks agree on a new value, so short glitches are discarded. The sample tick comes from one of two sources: a CPU-cycle strobe input, or a tick on every 64th clock from a free-running prescaler. The filtered level of pin A, and the synchronized level of pin B, each feed an edge detector. A 4-bit mode register for each pin selects which edge that detector reports. Pin C is synchronized and reports rising edges only.

Software loads each mode register as a whole nibble through its own write strobe. Each request flag stays raised until its clear bit is pulsed. While the standby input is high, the filter of pin A is frozen. Prioritisation, masking and vectoring belong to the logic that consumes the flags.

Top module: `int_edge_cond`

## Requirements
- R1: After reset, all three flags read 0 and both mode registers hold 0, so pins A and B detect rising edges.
- R2: Mode bits [1:0] pick the edge for their pin (mode A for pin A, mode B for pin B): 00 rising, 01 falling, 10 both, 11 none. Pin B is only synchronized, not filtered. Writes replace all four bits.
- R3: A pulse on pin A shorter than one sample period never raises flag 0. A pulse between one and two periods may or may not raise it.
- R4: A pulse on pin A that lasts two or more sample periods always raises flag 0.
- R5: With mode A bit 3 at 0, the filter samples on the CPU-cycle strobe. With bit 3 at 1, it samples once every 64 clocks from a free-running prescaler and ignores the strobe.
- R6: Pin C raises flag 2 on a rising edge and never on a falling edge.
- R7: Flags are indexed 0 for A, 1 for B and 2 for C. A raised flag holds until its own clear bit is pulsed, and a clear bit affects only its own flag.
- R8: When a set and a clear of the same flag fall in one cycle, the flag ends up set.
- R9: While standby is high, the pin A filter does not change, so pin A activity in standby raises no request.
- R10: Writing a new mode while a pin holds a steady level raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_tick | input | 1 | CPU-cycle sample strobe for the pin A filter |
| standby | input | 1 | Freezes the pin A filter while high |
| pin_a | input | 1 | Filtered interrupt pin |
| pin_b | input | 1 | Programmable-edge interrupt pin |
| pin_c | input | 1 | Rising-edge-only interrupt pin |
| mode_a_we | input | 1 | Write strobe for mode A |
| mode_a_wdata | input | 4 | Mode A value: [3] sample source, [1:0] edge |
| mode_b_we | input | 1 | Write strobe for mode B |
| mode_b_wdata | input | 4 | Mode B value: [1:0] edge |
| flag_clr | input | 3 | Per-flag clear pulses |
| req_flag | output | 3 | Sticky request flags |

## Verification
A flag's set and its clear can land in the same cycle. The bench provokes this by counting the two synchronizer stages after a rise on pin C, then pulsing clear bit 2 for exactly the cycle in which that edge is registered. It judges the outcome by reading flag 2 as 1 afterwards, and by a later lone clear that brings the flag to 0. This shows the clear path works and that the set won only because of the collision.

// File: rtl/int_edge_cond.sv
module int_edge_cond #(
  parameter int DIV  = 64,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cyc_tick,
  input  logic       standby,
  input  logic       pin_a,
  input  logic       pin_b,
  input  logic       pin_c,
  input  logic       mode_a_we,
  input  logic [3:0] mode_a_wdata,
  input  logic       mode_b_we,
  input  logic [3:0] mode_b_wdata,
  input  logic [2:0] flag_clr,
  output logic [2:0] req_flag
);
  localparam int PW = $clog2(DIV);

  logic [3:0]      mode_a_q, mode_b_q;
  logic [PW-1:0]   pre_q;
  logic [SYNC-1:0] sa_q, sb_q, sc_q;
  logic            samp_q, filt_q, pa_q, pb_q, pc_q;
  logic [2:0]      set;

  wire lvl_a    = sa_q[SYNC-1];
  wire lvl_b    = sb_q[SYNC-1];
  wire lvl_c    = sc_q[SYNC-1];
  wire pre_tick = (pre_q == PW'(DIV - 1));
  wire tick_a   = !standby && (mode_a_q[3] ? pre_tick : cyc_tick);
  wire unused_mode_bits = ^{mode_a_q[2], mode_b_q[3:2]};

  function automatic logic edge_hit(input logic [1:0] m, input logic cur, input logic prev);
    case (m)
      2'b00:   edge_hit = cur & ~prev;
      2'b01:   edge_hit = ~cur & prev;
      2'b10:   edge_hit = cur ^ prev;
      default: edge_hit = 1'b0;
    endcase
  endfunction

  assign set[0] = edge_hit(mode_a_q[1:0], filt_q, pa_q);
  assign set[1] = edge_hit(mode_b_q[1:0], lvl_b, pb_q);
  assign set[2] = lvl_c & ~pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_a_q <= '0;
      mode_b_q <= '0;
      pre_q    <= '0;
      sa_q     <= '0;
      sb_q     <= '0;
      sc_q     <= '0;
      samp_q   <= 1'b0;
      filt_q   <= 1'b0;
      pa_q     <= 1'b0;
      pb_q     <= 1'b0;
      pc_q     <= 1'b0;
      req_flag <= '0;
    end else begin
      pre_q <= pre_tick ? '0 : pre_q + 1'b1;
      sa_q  <= {sa_q[SYNC-2:0], pin_a};
      sb_q  <= {sb_q[SYNC-2:0], pin_b};
      sc_q  <= {sc_q[SYNC-2:0], pin_c};
      if (tick_a) begin
        samp_q <= lvl_a;
        if (lvl_a == samp_q) filt_q <= lvl_a;
      end
      pa_q <= filt_q;
      pb_q <= lvl_b;
      pc_q <= lvl_c;
      if (mode_a_we) mode_a_q <= mode_a_wdata;
      if (mode_b_we) mode_b_q <= mode_b_wdata;
      req_flag <= (req_flag & ~flag_clr) | set;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (req_flag == 3'b000 && mode_a_q == 4'h0 && mode_b_q == 4'h0));

  assert_standby_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    standby |=> $stable(filt_q));

  assert_filter_agree_R3: assert property (@(posedge clk) disable iff (rst)
    (filt_q != lvl_a || filt_q != samp_q) && !(tick_a && lvl_a == samp_q) |=> $stable(filt_q));

  assert_pin_c_rise_only_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(req_flag[2]) |-> $past(lvl_c));

  assert_mode_off_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_b_q[1:0] == 2'b11 && !req_flag[1]) |=> !req_flag[1]);

  genvar gi;
  for (gi = 0; gi < 3; gi++) begin : g_hold
    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (req_flag[gi] && !flag_clr[gi]) |=> req_flag[gi]);
  end
endmodule

// File: tb/tb_int_edge_cond.sv
module tb_int_edge_cond;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_tick = 1'b1, standby = 1'b0;
  logic       pin_a = 1'b0, pin_b = 1'b0, pin_c = 1'b0;
  logic       mode_a_we = 1'b0, mode_b_we = 1'b0;
  logic [3:0] mode_a_wdata = '0, mode_b_wdata = '0;
  logic [2:0] flag_clr = '0;
  logic [2:0] req_flag;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  int_edge_cond dut (.*);

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: flags=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clr_all();
    flag_clr = 3'b111; cyc(1); flag_clr = 3'b000; cyc(1);
  endtask

  task automatic wr_a(input logic [3:0] v);
    mode_a_wdata = v; mode_a_we = 1'b1; cyc(1); mode_a_we = 1'b0; cyc(1);
  endtask

  task automatic wr_b(input logic [3:0] v);
    mode_b_wdata = v; mode_b_we = 1'b1; cyc(1); mode_b_we = 1'b0; cyc(1);
  endtask

  task automatic t_reset();
    chk("R1 reset flags", req_flag, 3'b000);
    pin_a = 1'b1; pin_b = 1'b1; cyc(8);
    chk("R1 default rising", req_flag, 3'b011);
    clr_all();
    pin_a = 1'b0; pin_b = 1'b0; cyc(8);
    chk("R1 falling ignored by default", req_flag, 3'b000);
  endtask

  task automatic t_modes();
    wr_b(4'b0001);
    pin_b = 1'b1; cyc(6); chk("R2 B falling mode ignores rise", req_flag, 3'b000);
    pin_b = 1'b0; cyc(6); chk("R2 B falling mode", req_flag, 3'b010);
    clr_all();
    wr_b(4'b0010);
    pin_b = 1'b1; cyc(6); chk("R2 B both rise", req_flag, 3'b010);
    clr_all();
    pin_b = 1'b0; cyc(6); chk("R2 B both fall", req_flag, 3'b010);
    clr_all();
    wr_b(4'b0011);
    pin_b = 1'b1; cyc(6); pin_b = 1'b0; cyc(6);
    chk("R2 B disabled", req_flag, 3'b000);
    wr_a(4'b0001);
    pin_a = 1'b1; cyc(8); chk("R2 A falling mode ignores rise", req_flag, 3'b000);
    pin_a = 1'b0; cyc(8); chk("R2 A falling mode", req_flag, 3'b001);
    clr_all();
    wr_a(4'b0000); wr_b(4'b0000);
  endtask

  task automatic t_filter();
    pin_a = 1'b1; cyc(1); pin_a = 1'b0; cyc(10);
    chk("R3 one-period glitch rejected", req_flag, 3'b000);
    pin_a = 1'b1; cyc(3); pin_a = 1'b0; cyc(10);
    chk("R4 three-period pulse accepted", req_flag, 3'b001);
    clr_all();
  endtask

  task automatic t_prescale();
    cyc_tick = 1'b0;
    pin_a = 1'b1; cyc(20); pin_a = 1'b0; cyc(10);
    chk("R5 no strobe no sample", req_flag, 3'b000);
    cyc_tick = 1'b1;
    wr_a(4'b1000);
    pin_a = 1'b1; cyc(40); pin_a = 1'b0; cyc(200);
    chk("R3 R5 short pulse vs 64-clock tick", req_flag, 3'b000);
    pin_a = 1'b1; cyc(140); pin_a = 1'b0; cyc(200);
    chk("R4 R5 long pulse vs 64-clock tick", req_flag, 3'b001);
    clr_all();
    wr_a(4'b0000);
  endtask

  task automatic t_pinc();
    pin_c = 1'b1; cyc(5); chk("R6 C rise", req_flag, 3'b100);
    clr_all();
    pin_c = 1'b0; cyc(5); chk("R6 C fall ignored", req_flag, 3'b000);
  endtask

  task automatic t_sticky();
    pin_b = 1'b1; pin_c = 1'b1; cyc(30);
    chk("R7 flags held", req_flag, 3'b110);
    flag_clr = 3'b010; cyc(1); flag_clr = 3'b000; cyc(1);
    chk("R7 own clear only", req_flag, 3'b100);
    flag_clr = 3'b100; cyc(1); flag_clr = 3'b000; cyc(1);
    pin_b = 1'b0; pin_c = 1'b0; cyc(6);
    chk("R7 all cleared", req_flag, 3'b000);
  endtask

  task automatic t_setwins();
    pin_c = 1'b1; cyc(2);
    flag_clr = 3'b100; cyc(1); flag_clr = 3'b000;
    chk("R8 set beats clear", req_flag, 3'b100);
    cyc(3);
    flag_clr = 3'b100; cyc(1); flag_clr = 3'b000;
    chk("R8 lone clear", req_flag, 3'b000);
    pin_c = 1'b0; cyc(5);
  endtask

  task automatic t_standby();
    standby = 1'b1;
    pin_a = 1'b1; cyc(10); pin_a = 1'b0; cyc(6);
    standby = 1'b0; cyc(10);
    chk("R9 standby freezes filter", req_flag, 3'b000);
  endtask

  task automatic t_modechange();
    pin_a = 1'b1; pin_b = 1'b1; cyc(8); clr_all();
    wr_b(4'b0001); wr_b(4'b0010); wr_a(4'b0010); cyc(6);
    chk("R10 no false request on mode write", req_flag, 3'b000);
    wr_b(4'b0000); wr_a(4'b0000);
    pin_a = 1'b0; pin_b = 1'b0; cyc(8);
    chk("R10 rising mode ignores fall", req_flag, 3'b000);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: flags=%b expected=finish", req_flag);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3); rst = 1'b0; cyc(2);
    t_reset();
    t_modes();
    t_filter();
    t_prescale();
    t_pinc();
    t_sticky();
    t_setwins();
    t_standby();
    t_modechange();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule